// File: doc/BRIEF.md
# I2C Slave with Maskable Address Compare

This block is the slave side of an I2C bus. It runs from a fast system clock and watches SCL and SDA through synchronisers. It recognises 7-bit or 10-bit addresses. A per-bit mask marks address bits as don't-care, so one slave can answer to a whole group of addresses. When it is addressed for a write, it acknowledges and collects data bytes into a receive buffer. When it is addressed for a read, it sends the byte held in a transmit buffer, most significant bit first.

SDA is handled as an open-drain line: the block only ever asserts a pull-low request. SCL is observed but never held, because the block does no clock stretching. Separate one-cycle pulses report each Start and each Stop condition seen on the bus, so that firmware can run a bus master on top of the same pins. A single enable input gates everything: while it is low the block stays in reset and leaves both lines alone.

Top module: `i2cm_slave`

## Requirements
- R1: In 7-bit mode (ten_bit=0), a first byte whose upper seven bits equal own_addr[6:0] is acknowledged: sda_pull is high during the 9th SCL clock. Bit 0 of that byte is the direction, with 0 meaning write and 1 meaning read. Each following write byte is acknowledged, copied into rx_data, and sets rx_full.
- R2: A 1 in addr_mask makes the matching address bit don't-care. An address that differs from own_addr only in masked bits is acknowledged. An address that differs in any unmasked bit is not acknowledged, and the bytes that follow are not acknowledged and leave rx_full unchanged.
- R3: There is no general-call response. A first byte of 0x00 is acknowledged only if address 0 passes the normal masked compare.
- R4: In 10-bit mode (ten_bit=1), a write needs two bytes. The first is 11110, then own_addr[9:8], then 0. The second equals own_addr[7:0]. Both bytes are compared under the mask. The block acknowledges the second byte only on a match, and only then accepts data.
- R5: A 10-bit read header (11110, then own_addr[9:8], then 1) is acknowledged only after a full 10-bit write match in the same transfer, with only repeated Starts in between. A Stop cancels that earlier match.
- R6: In a read, the transmit buffer (written by tx_we/tx_wdata) is sent MSB first, starting after the address acknowledge. The buffer is reloaded after each byte the master acknowledges. A master NACK ends the transfer and SDA stays released until the next Start.
- R7: start_irq pulses for one cycle for each Start, including a repeated Start, where a Start is SDA falling while SCL is high. stop_irq pulses for one cycle for each Stop, where a Stop is SDA rising while SCL is high.
- R8: While en is low, sda_pull stays low, no flags pulse, and all state is cleared.
- R9: A data byte that completes while rx_full is still set is not acknowledged, and rx_data keeps its earlier value. A pulse on rx_clear clears rx_full.
- R10: sda_pull only changes while SCL is low, so SDA stays stable during SCL high.
- R11: A repeated Start returns the block to address matching, and a Stop returns it to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low holds the block in reset |
| ten_bit | input | 1 | 1 selects 10-bit addressing |
| own_addr | input | 10 | Slave address (7-bit mode uses bits 6:0) |
| addr_mask | input | 10 | 1 marks an address bit as don't-care |
| tx_we | input | 1 | Write strobe for the transmit buffer |
| tx_wdata | input | 8 | Transmit buffer data |
| rx_clear | input | 1 | Pulse to clear rx_full after reading rx_data |
| rx_data | output | 8 | Last received data byte |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| start_irq | output | 1 | One-cycle pulse on a Start condition |
| stop_irq | output | 1 | One-cycle pulse on a Stop condition |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain) |

## Verification
The bench targets the mask edge, where a design that ignores the mask, or inverts its sense, either rejects the group address or accepts a neighbour that differs in an unmasked bit. It sends a 0x00 first byte, so a block that still answers general call acknowledges it. It tries a 10-bit read header with no earlier write match and with a wrong low byte; a design that forgets the stored match, or keeps it across a Stop, would send data to the wrong transfer. It also covers a repeated Start to a foreign address after a valid write and a data byte arriving while the buffer is still full. A block that did not return to address matching, or that overwrote rx_data, shows up in the acknowledge bit and in the held data.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 10;
    localparam int BITCNT_W  = 4;
    localparam logic [4:0] TEN_HDR = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_RX,
        ST_TX,
        ST_SKIP
    } st_e;

    typedef struct packed {
        logic scl_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic hit7;
        logic hit_hi_w;
        logic hit_hi_r;
        logic hit_lo;
    } match_t;

    function automatic logic masked_eq(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] b,
                                       input logic [ADDR_W-1:0] m);
        return ((a ^ b) & ~m) == '0;
    endfunction

endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync
    import i2cm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_p, sda_p;
    logic              s_scl, s_sda;

    assign s_scl = scl_q[STAGES-1];
    assign s_sda = sda_q[STAGES-1];

    // idle bus is high: reset to 1 so no edge is seen on release
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_p <= s_scl;
            sda_p <= s_sda;
        end
    end

    always_comb begin
        ev.scl_lvl  = s_scl;
        ev.sda      = s_sda;
        ev.scl_rise = s_scl & ~scl_p;
        ev.scl_fall = ~s_scl & scl_p;
        ev.start    = s_scl & scl_p & sda_p & ~s_sda;
        ev.stop     = s_scl & scl_p & ~sda_p & s_sda;
    end

    a_r7_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ev.start && ev.stop) && !(ev.scl_rise && ev.scl_fall));

endmodule

// File: rtl/i2cm_addr_match.sv
module i2cm_addr_match
    import i2cm_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] addr_mask,
    input  logic              ten_bit,
    input  logic              ten_armed,
    output match_t            hits
);
    localparam int PAD7 = ADDR_W - 7;
    localparam int PAD8 = ADDR_W - BYTE_W;

    logic hdr_ok;

    always_comb begin
        hdr_ok = (rx_byte[7:3] == TEN_HDR) &&
                 (((rx_byte[2:1] ^ own_addr[9:8]) & ~addr_mask[9:8]) == 2'b00);

        hits.hit7     = ~ten_bit &&
                        masked_eq({{PAD7{1'b0}}, rx_byte[7:1]},
                                  {{PAD7{1'b0}}, own_addr[6:0]},
                                  {{PAD7{1'b0}}, addr_mask[6:0]});
        hits.hit_hi_w = ten_bit & hdr_ok & ~rx_byte[0];
        hits.hit_hi_r = ten_bit & hdr_ok & rx_byte[0] & ten_armed;
        hits.hit_lo   = masked_eq({{PAD8{1'b0}}, rx_byte},
                                  {{PAD8{1'b0}}, own_addr[7:0]},
                                  {{PAD8{1'b0}}, addr_mask[7:0]});
    end

endmodule

// File: rtl/i2cm_proto.sv
module i2cm_proto
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  match_t            hits,
    input  logic [BYTE_W-1:0] tx_buf,
    input  logic              rx_clear,
    output logic [BYTE_W-1:0] shreg,
    output logic              ten_armed,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_full,
    output logic              start_irq,
    output logic              stop_irq
);
    localparam logic [BITCNT_W-1:0] ACK_BIT  = BITCNT_W'(BYTE_W);
    localparam logic [BITCNT_W-1:0] END_BIT  = BITCNT_W'(BYTE_W + 1);

    st_e                 st, nst;
    logic [BITCNT_W-1:0] cnt;
    logic [BYTE_W-1:0]   tsh;
    logic                m_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            nst       <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            tsh       <= '0;
            m_ack     <= 1'b0;
            ten_armed <= 1'b0;
            sda_pull  <= 1'b0;
            rx_data   <= '0;
            rx_full   <= 1'b0;
            start_irq <= 1'b0;
            stop_irq  <= 1'b0;
        end else begin
            start_irq <= ev.start;
            stop_irq  <= ev.stop;
            if (rx_clear) rx_full <= 1'b0;

            if (ev.stop) begin
                st        <= ST_IDLE;
                cnt       <= '0;
                sda_pull  <= 1'b0;
                ten_armed <= 1'b0;
            end else if (ev.start) begin
                st       <= ST_ADDR_HI;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else if (st != ST_IDLE && st != ST_SKIP) begin
                if (ev.scl_rise) begin
                    if (cnt < ACK_BIT)
                        shreg <= {shreg[BYTE_W-2:0], ev.sda};
                    else if (st == ST_TX)
                        m_ack <= ~ev.sda;
                    cnt <= cnt + 1'b1;
                end else if (ev.scl_fall) begin
                    if (cnt == ACK_BIT) begin
                        // acknowledge phase opens: decide whether to pull
                        unique case (st)
                            ST_ADDR_HI: begin
                                if (hits.hit7) begin
                                    sda_pull <= 1'b1;
                                    nst      <= shreg[0] ? ST_TX : ST_RX;
                                end else if (hits.hit_hi_w) begin
                                    sda_pull <= 1'b1;
                                    nst      <= ST_ADDR_LO;
                                end else if (hits.hit_hi_r) begin
                                    sda_pull <= 1'b1;
                                    nst      <= ST_TX;
                                end else begin
                                    sda_pull <= 1'b0;
                                    nst      <= ST_SKIP;
                                end
                            end
                            ST_ADDR_LO: begin
                                if (hits.hit_lo) begin
                                    sda_pull  <= 1'b1;
                                    ten_armed <= 1'b1;
                                    nst       <= ST_RX;
                                end else begin
                                    sda_pull <= 1'b0;
                                    nst      <= ST_SKIP;
                                end
                            end
                            ST_RX: begin
                                if (!rx_full || rx_clear) begin
                                    sda_pull <= 1'b1;
                                    rx_data  <= shreg;
                                    rx_full  <= 1'b1;
                                end else begin
                                    sda_pull <= 1'b0;
                                end
                                nst <= ST_RX;
                            end
                            ST_TX: begin
                                sda_pull <= 1'b0;
                                nst      <= ST_TX;
                            end
                            default: nst <= ST_SKIP;
                        endcase
                    end else if (cnt == END_BIT) begin
                        cnt <= '0;
                        if (nst == ST_TX && (st != ST_TX || m_ack)) begin
                            st       <= ST_TX;
                            tsh      <= tx_buf;
                            sda_pull <= ~tx_buf[BYTE_W-1];
                        end else if (nst == ST_TX) begin
                            st       <= ST_SKIP;
                            sda_pull <= 1'b0;
                        end else begin
                            st       <= nst;
                            sda_pull <= 1'b0;
                        end
                    end else if (st == ST_TX && cnt != '0) begin
                        sda_pull <= ~tsh[BYTE_W-2];
                        tsh      <= {tsh[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // R10: the pull request only asserts while the synchronised SCL is low
    a_r10_pull_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !ev.scl_lvl);

    // R9: a byte finishing against a full buffer is not acknowledged
    a_r9_full_nack: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RX && ev.scl_fall && cnt == ACK_BIT && rx_full && !rx_clear
         && !ev.start && !ev.stop) |=> !sda_pull);

    a_r7_flag_pulses: assert property (@(posedge clk) disable iff (rst)
        !(start_irq && stop_irq));

    // R11: a stop always leaves SDA released
    a_r11_stop_releases: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_pull);

endmodule

// File: rtl/i2cm_slave.sv
module i2cm_slave
    import i2cm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ten_bit,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] addr_mask,
    input  logic              tx_we,
    input  logic [BYTE_W-1:0] tx_wdata,
    input  logic              rx_clear,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_full,
    output logic              start_irq,
    output logic              stop_irq,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull
);
    logic              blk_rst;
    bus_ev_t           ev;
    match_t            hits;
    logic [BYTE_W-1:0] shreg;
    logic              ten_armed;
    logic [BYTE_W-1:0] tx_buf;

    assign blk_rst = rst | ~en;

    always_ff @(posedge clk) begin
        if (blk_rst)    tx_buf <= '0;
        else if (tx_we) tx_buf <= tx_wdata;
    end

    i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (blk_rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2cm_addr_match u_match (
        .rx_byte   (shreg),
        .own_addr  (own_addr),
        .addr_mask (addr_mask),
        .ten_bit   (ten_bit),
        .ten_armed (ten_armed),
        .hits      (hits)
    );

    i2cm_proto u_proto (
        .clk       (clk),
        .rst       (blk_rst),
        .ev        (ev),
        .hits      (hits),
        .tx_buf    (tx_buf),
        .rx_clear  (rx_clear),
        .shreg     (shreg),
        .ten_armed (ten_armed),
        .sda_pull  (sda_pull),
        .rx_data   (rx_data),
        .rx_full   (rx_full),
        .start_irq (start_irq),
        .stop_irq  (stop_irq)
    );

    // R8: disabled block leaves SDA alone and raises no flags
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!sda_pull && !start_irq && !stop_irq));

endmodule

// File: tb/i2cm_slave_bench.sv
module i2cm_slave_bench;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       ten_bit = 1'b0;
    logic [9:0] own_addr = 10'h052;
    logic [9:0] addr_mask = 10'h000;
    logic       tx_we = 1'b0;
    logic [7:0] tx_wdata = 8'h00;
    logic       rx_clear = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, start_irq, stop_irq, sda_pull;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;

    int checks = 0;
    int failures = 0;
    int n_start = 0;
    int n_stop = 0;
    int n_bad_change = 0;
    logic prev_pull = 1'b0;
    bit done = 1'b0;

    assign sda_bus = sda_m & ~sda_pull;

    always #2 clk = ~clk;

    i2cm_slave u_i2cm_slave (
        .clk(clk), .rst(rst), .en(en), .ten_bit(ten_bit),
        .own_addr(own_addr), .addr_mask(addr_mask),
        .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_clear(rx_clear),
        .rx_data(rx_data), .rx_full(rx_full),
        .start_irq(start_irq), .stop_irq(stop_irq),
        .scl_in(scl_m), .sda_in(sda_bus), .sda_pull(sda_pull)
    );

    always @(posedge clk) begin
        if (start_irq) n_start++;
        if (stop_irq)  n_stop++;
        if (sda_pull != prev_pull && scl_m) n_bad_change++;
        prev_pull <= sda_pull;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic d, output logic s);
        sda_m = d;
        wait_c(H);
        scl_m = 1'b1;
        wait_c(H);
        s = sda_bus;
        wait_c(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_c(H);
        scl_m = 1'b1; wait_c(H);
        sda_m = 1'b0; wait_c(H);
        scl_m = 1'b0; wait_c(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_c(H);
        scl_m = 1'b1; wait_c(H);
        sda_m = 1'b1; wait_c(4 * H);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~give_ack, s);
    endtask

    task automatic load_tx(input logic [7:0] v);
        tx_wdata = v; tx_we = 1'b1;
        @(negedge clk); tx_we = 1'b0;
    endtask

    task automatic clear_rx();
        rx_clear = 1'b1;
        @(negedge clk); rx_clear = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8 reset pull", sda_pull, 0);
        chk("R8 reset full", rx_full, 0);
        chk("R7 reset flags", {start_irq, stop_irq}, 0);
    endtask

    task automatic t_seven_write();
        logic a; int s0, p0;
        ten_bit = 0; own_addr = 10'h052; addr_mask = 0;
        s0 = n_start; p0 = n_stop;
        bus_start();
        wr_byte(8'hA4, a); chk("R1 addr ack", a, 1);
        wr_byte(8'hA5, a); chk("R1 data ack", a, 1);
        wait_c(4);
        chk("R1 rx_data", rx_data, 8'hA5);
        chk("R1 rx_full", rx_full, 1);
        bus_stop();
        chk("R7 start count", n_start - s0, 1);
        chk("R7 stop count", n_stop - p0, 1);
        clear_rx(); wait_c(2);
        chk("R9 clear", rx_full, 0);
    endtask

    task automatic t_mask();
        logic a;
        own_addr = 10'h052; addr_mask = 10'h003;
        bus_start();
        wr_byte(8'hA2, a); chk("R2 masked match ack", a, 1);
        bus_stop();
        bus_start();
        wr_byte(8'hAC, a); chk("R2 unmasked differ nack", a, 0);
        wr_byte(8'h3C, a); chk("R2 data after miss nack", a, 0);
        bus_stop();
        chk("R2 rx_full untouched", rx_full, 0);
        addr_mask = 0;
    endtask

    task automatic t_gcall();
        logic a;
        own_addr = 10'h052;
        bus_start();
        wr_byte(8'h00, a); chk("R3 general call nack", a, 0);
        bus_stop();
        own_addr = 10'h000;
        bus_start();
        wr_byte(8'h00, a); chk("R3 zero by compare ack", a, 1);
        bus_stop();
        own_addr = 10'h052;
    endtask

    task automatic t_overflow();
        logic a;
        bus_start();
        wr_byte(8'hA4, a);
        wr_byte(8'h11, a); chk("R9 first ack", a, 1);
        wr_byte(8'h22, a); chk("R9 full nack", a, 0);
        bus_stop();
        chk("R9 data kept", rx_data, 8'h11);
        chk("R9 still full", rx_full, 1);
        clear_rx(); wait_c(2);
        chk("R9 cleared", rx_full, 0);
    endtask

    task automatic t_seven_read();
        logic a; logic [7:0] d;
        load_tx(8'hB1);
        bus_start();
        wr_byte(8'hA5, a); chk("R1 read addr ack", a, 1);
        rd_byte(1'b1, d);
        load_tx(8'h6E);
        chk("R6 first byte msb first", d, 8'hB1);
        rd_byte(1'b0, d);
        chk("R6 reload after ack", d, 8'h6E);
        wait_c(2 * H);
        chk("R6 released after nack", sda_pull, 0);
        bus_stop();
    endtask

    task automatic t_ten();
        logic a; logic [7:0] d;
        ten_bit = 1; own_addr = 10'h2A7; addr_mask = 0;
        load_tx(8'h4D);
        bus_start();
        wr_byte(8'hF4, a); chk("R4 header ack", a, 1);
        wr_byte(8'hA7, a); chk("R4 low byte ack", a, 1);
        wr_byte(8'h99, a); chk("R4 data ack", a, 1);
        wait_c(4);
        chk("R4 rx_data", rx_data, 8'h99);
        clear_rx();
        bus_start();
        wr_byte(8'hF5, a); chk("R5 read header ack", a, 1);
        rd_byte(1'b0, d); chk("R5 read data", d, 8'h4D);
        bus_stop();
        bus_start();
        wr_byte(8'hF5, a); chk("R5 read header unarmed nack", a, 0);
        bus_stop();
        bus_start();
        wr_byte(8'hF4, a);
        wr_byte(8'hA6, a); chk("R4 wrong low byte nack", a, 0);
        bus_stop();
        addr_mask = 10'h001;
        bus_start();
        wr_byte(8'hF4, a);
        wr_byte(8'hA6, a); chk("R4 masked low byte ack", a, 1);
        bus_stop();
        addr_mask = 0; ten_bit = 0; own_addr = 10'h052;
        clear_rx();
    endtask

    task automatic t_restart();
        logic a;
        bus_start();
        wr_byte(8'hA4, a);
        wr_byte(8'h10, a); chk("R11 data ack", a, 1);
        clear_rx();
        bus_start();
        wr_byte(8'hC0, a); chk("R11 restart foreign nack", a, 0);
        wr_byte(8'h77, a); chk("R11 ignored after restart", a, 0);
        chk("R11 rx_data held", rx_data, 8'h10);
        bus_start();
        wr_byte(8'hA4, a); chk("R11 restart own ack", a, 1);
        bus_stop();
        wait_c(4);
        chk("R11 idle released", sda_pull, 0);
    endtask

    task automatic t_disable();
        logic a; int s0, p0;
        en = 0;
        s0 = n_start; p0 = n_stop;
        bus_start();
        wr_byte(8'hA4, a); chk("R8 disabled nack", a, 0);
        bus_stop();
        chk("R8 no flags", (n_start - s0) + (n_stop - p0), 0);
        en = 1; wait_c(4);
    endtask

    initial begin
        wait_c(5);
        rst = 0; en = 1;
        wait_c(5);
        t_reset();
        t_seven_write();
        t_mask();
        t_gcall();
        t_overflow();
        t_seven_read();
        t_ten();
        t_restart();
        t_disable();
        chk("R10 pull changes only with SCL low", n_bad_change, 0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule